// File: doc/BRIEF.md
# Overlay Keying Mixer with Colour-Bar Sequencer

This block sits in front of a video encoder and decides, pixel by pixel, what colour is sent to two destinations. One is the encoded path, which later becomes luma, chroma and composite video. The other is the RGB path. For each pixel it passes either the main 24-bit video sample or an overlay colour. The overlay colour comes from a small programmable colour table. There is one table for each destination, and a 3-bit overlay code picks the entry. A key input, whose active level can be programmed, makes the choice. Software can turn keying off for the encoded path alone. On-screen data then shows on RGB but not in the encoded signal.

A colour-bar mode reuses the same two tables as a test-pattern source that needs no external input. Across each active line the block reads entries 0 to 7 in turn, in eight equal segments. Outside active video both destinations carry a programmable blanking colour. Software loads the tables and controls through a single write port made of an address, a data word and a strobe. Every output is registered, so the latency is a fixed single cycle.

Top module: `ovl_key_mixer`

## Requirements
- R1: After a synchronous reset, both outputs are 0 and every table entry is 0. The blanking colour is 0, the key is active high, keying is enabled on both paths, and colour bars are off.
- R2: Each output is registered. The value seen after clock edge N depends only on the inputs and register contents that were present before edge N.
- R3: Write address map: 0 to 7 load encoded-path table entries 0 to 7; 8 to 15 load RGB table entries 0 to 7; 16 loads the control word; 17 loads the blanking colour.
- R4: With control bit 0 clear, key = 1 selects the overlay. With bit 0 set, key = 0 selects the overlay. When the overlay is not selected, the main sample is passed.
- R5: When the overlay is selected, the encoded path carries encoded-table entry `ovl_code` and the RGB path carries RGB-table entry `ovl_code`.
- R6: With control bit 1 set, the encoded path passes the main sample during active video even when the key selects the overlay. The RGB path keeps keying.
- R7: While `active` is low, both outputs carry the blanking colour.
- R8: With control bit 2 set, active pixel p of a line (counted from 0 at the rising edge of `active`) outputs table entry min(p / (ACTIVE_PIX/8), 7) on each path. The sequence starts again at entry 0 on every line.
- R9: In colour-bar mode the key, the overlay code and the main sample have no effect on either output.
- R10: A table write during active video changes the output from the next pixel onward. The pixel registered at the same edge as the write still uses the old entry.
- R11: Writes to addresses 18 to 31 change no table, control or blanking state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | 24 | Register write data |
| active | input | 1 | High during active video pixels |
| key | input | 1 | Overlay key |
| ovl_code | input | 3 | Overlay colour index |
| main_pix | input | 24 | Main video sample |
| enc_pix | output | 24 | Pixel to the encoded path |
| rgb_pix | output | 24 | Pixel to the RGB path |

## Verification
The bench builds the block with ACTIVE_PIX = 32, which gives segments of four pixels. A single line of forty pixels therefore covers all eight colour-bar steps, the saturation at entry 7 past the nominal width, and the restart on the next line. The short width also leaves room to land a table write inside a running bar segment and to sweep the key polarity and encoded-path keying settings across many pseudo-random key and code patterns.

// File: rtl/ovl_mix_pkg.sv
package ovl_mix_pkg;
    localparam int PIX_W  = 24;
    localparam int IDX_W  = 3;
    localparam int N_ENT  = 1 << IDX_W;
    localparam int ADDR_W = 5;

    localparam int ENC_BASE   = 0;
    localparam int RGB_BASE   = ENC_BASE + N_ENT;
    localparam int CTRL_ADDR  = RGB_BASE + N_ENT;
    localparam int BLANK_ADDR = CTRL_ADDR + 1;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [N_ENT-1:0][PIX_W-1:0] tab_t;

    typedef struct packed {
        logic bar_en;
        logic enc_key_off;
        logic key_low;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_BLANK,
        SRC_MAIN,
        SRC_OVL,
        SRC_BAR
    } src_e;

    function automatic ctrl_t ctrl_from_word(input pix_t w);
        ctrl_t c;
        c.key_low     = w[0];
        c.enc_key_off = w[1];
        c.bar_en      = w[2];
        return c;
    endfunction

    function automatic logic key_hit(input logic k, input ctrl_t c);
        return k ^ c.key_low;
    endfunction
endpackage

// File: rtl/ovl_regs.sv
module ovl_regs
    import ovl_mix_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  pix_t              wdata,
    output ctrl_t             ctrl,
    output pix_t              blank,
    output tab_t              enc_tab,
    output tab_t              rgb_tab
);
    ctrl_t ctrl_q;
    pix_t  blank_q;

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        localparam logic [ADDR_W-1:0] A_ENC = ADDR_W'(ENC_BASE + e);
        localparam logic [ADDR_W-1:0] A_RGB = ADDR_W'(RGB_BASE + e);
        pix_t enc_q;
        pix_t rgb_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                enc_q <= '0;
                rgb_q <= '0;
            end else if (we) begin
                if (addr == A_ENC) enc_q <= wdata;
                if (addr == A_RGB) rgb_q <= wdata;
            end
        end

        assign enc_tab[e] = enc_q;
        assign rgb_tab[e] = rgb_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            blank_q <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(CTRL_ADDR))  ctrl_q  <= ctrl_from_word(wdata);
            if (addr == ADDR_W'(BLANK_ADDR)) blank_q <= wdata;
        end
    end

    assign ctrl  = ctrl_q;
    assign blank = blank_q;
endmodule

// File: rtl/ovl_bar_seq.sv
module ovl_bar_seq
    import ovl_mix_pkg::*;
#(
    parameter int SEG_LEN = 90
) (
    input  logic clk,
    input  logic rst,
    input  logic act,
    output idx_t seg
);
    localparam int CNT_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEG_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    idx_t             seg_q;
    logic             seg_done;
    logic             at_last;

    assign seg_done = (cnt_q == CNT_LAST);
    assign at_last  = (seg_q == idx_t'(N_ENT - 1));

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            cnt_q <= '0;
            seg_q <= '0;
        end else if (seg_done) begin
            cnt_q <= '0;
            if (!at_last) seg_q <= seg_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign seg = seg_q;
endmodule

// File: rtl/ovl_select.sv
module ovl_select
    import ovl_mix_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  act,
    input  logic  key,
    input  idx_t  code,
    input  pix_t  main_pix,
    input  idx_t  seg,
    input  ctrl_t ctrl,
    input  pix_t  blank,
    input  tab_t  enc_tab,
    input  tab_t  rgb_tab,
    output pix_t  enc_pix,
    output pix_t  rgb_pix
);
    pix_t path_q [2];

    for (genvar p = 0; p < 2; p++) begin : g_path
        tab_t tab;
        logic keying_on;
        src_e src;
        pix_t nxt;

        assign tab       = (p == 0) ? enc_tab : rgb_tab;
        assign keying_on = (p == 0) ? ~ctrl.enc_key_off : 1'b1;

        always_comb begin
            if (!act)                                src = SRC_BLANK;
            else if (ctrl.bar_en)                    src = SRC_BAR;
            else if (key_hit(key, ctrl) && keying_on) src = SRC_OVL;
            else                                     src = SRC_MAIN;
        end

        always_comb begin
            case (src)
                SRC_BLANK: nxt = blank;
                SRC_BAR:   nxt = tab[seg];
                SRC_OVL:   nxt = tab[code];
                default:   nxt = main_pix;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) path_q[p] <= '0;
            else     path_q[p] <= nxt;
        end
    end

    assign enc_pix = path_q[0];
    assign rgb_pix = path_q[1];
endmodule

// File: rtl/ovl_key_mixer.sv
module ovl_key_mixer
    import ovl_mix_pkg::*;
#(
    parameter int ACTIVE_PIX = 720
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [4:0]  cfg_addr,
    input  logic [23:0] cfg_wdata,
    input  logic        active,
    input  logic        key,
    input  logic [2:0]  ovl_code,
    input  logic [23:0] main_pix,
    output logic [23:0] enc_pix,
    output logic [23:0] rgb_pix
);
    localparam int SEG_RAW = ACTIVE_PIX / N_ENT;
    localparam int SEG_LEN = (SEG_RAW < 1) ? 1 : SEG_RAW;

    ctrl_t ctrl_w;
    pix_t  blank_w;
    tab_t  enc_tab_w;
    tab_t  rgb_tab_w;
    idx_t  seg_w;

    ovl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .ctrl    (ctrl_w),
        .blank   (blank_w),
        .enc_tab (enc_tab_w),
        .rgb_tab (rgb_tab_w)
    );

    ovl_bar_seq #(.SEG_LEN(SEG_LEN)) u_bar (
        .clk (clk),
        .rst (rst),
        .act (active),
        .seg (seg_w)
    );

    ovl_select u_sel (
        .clk      (clk),
        .rst      (rst),
        .act      (active),
        .key      (key),
        .code     (ovl_code),
        .main_pix (main_pix),
        .seg      (seg_w),
        .ctrl     (ctrl_w),
        .blank    (blank_w),
        .enc_tab  (enc_tab_w),
        .rgb_tab  (rgb_tab_w),
        .enc_pix  (enc_pix),
        .rgb_pix  (rgb_pix)
    );
endmodule

// File: rtl/ovl_key_mixer_chk.sv
module ovl_key_mixer_chk
    import ovl_mix_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  active,
    input logic  key,
    input pix_t  main_pix,
    input pix_t  enc_pix,
    input pix_t  rgb_pix,
    input ctrl_t ctrl,
    input pix_t  blank,
    input idx_t  seg
);
    p_blank_r7: assert property (@(posedge clk) disable iff (rst)
        !active |=> (enc_pix == $past(blank) && rgb_pix == $past(blank)));

    p_seg_restart_r8: assert property (@(posedge clk) disable iff (rst)
        !active |=> (seg == '0));

    p_seg_step_r8: assert property (@(posedge clk) disable iff (rst)
        active |=> (seg == $past(seg) || seg == $past(seg) + 1'b1));

    p_enc_nokey_r6: assert property (@(posedge clk) disable iff (rst)
        (active && ctrl.enc_key_off && !ctrl.bar_en) |=> (enc_pix == $past(main_pix)));

    p_rgb_main_r4: assert property (@(posedge clk) disable iff (rst)
        (active && !ctrl.bar_en && (key == ctrl.key_low)) |=> (rgb_pix == $past(main_pix)));
endmodule

bind ovl_key_mixer ovl_key_mixer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .key      (key),
    .main_pix (main_pix),
    .enc_pix  (enc_pix),
    .rgb_pix  (rgb_pix),
    .ctrl     (ctrl_w),
    .blank    (blank_w),
    .seg      (seg_w)
);

// File: tb/ovl_key_mixer_bench.sv
module ovl_key_mixer_bench;
    localparam int AP  = 32;
    localparam int SEG = AP / 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        active = 1'b0;
    logic        key = 1'b0;
    logic [2:0]  ovl_code = '0;
    logic [23:0] main_pix = '0;
    logic [23:0] enc_pix;
    logic [23:0] rgb_pix;

    always #4 clk = ~clk;

    ovl_key_mixer #(.ACTIVE_PIX(AP)) u_ovl_key_mixer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .active(active), .key(key),
        .ovl_code(ovl_code), .main_pix(main_pix),
        .enc_pix(enc_pix), .rgb_pix(rgb_pix)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // behavioural reference state
    logic [23:0] m_enc [8];
    logic [23:0] m_rgb [8];
    logic [2:0]  m_ctrl;
    logic [23:0] m_blank;
    int          m_pos;
    logic [23:0] x_enc, x_rgb;
    string       x_tag;
    bit          x_valid = 0;
    logic [31:0] lf = 32'h1ACE_B00C;

    function automatic logic [31:0] nxt_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic check_now();
        tests++;
        if (enc_pix !== x_enc || rgb_pix !== x_rgb) begin
            fails++;
            $display("FAIL %s enc=%h rgb=%h expected enc=%h rgb=%h",
                     x_tag, enc_pix, rgb_pix, x_enc, x_rgb);
        end
    endtask

    task automatic cyc(input string tag, input logic we, input logic [4:0] a,
                       input logic [23:0] d, input logic ac, input logic k,
                       input logic [2:0] ix, input logic [23:0] mp);
        int s;
        logic sel;
        @(negedge clk);
        if (x_valid) check_now();
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        active = ac; key = k; ovl_code = ix; main_pix = mp;
        if (!ac) begin
            x_enc = m_blank; x_rgb = m_blank;
        end else if (m_ctrl[2]) begin
            s = m_pos / SEG;
            if (s > 7) s = 7;
            x_enc = m_enc[s]; x_rgb = m_rgb[s];
        end else begin
            sel   = k ^ m_ctrl[0];
            x_rgb = sel ? m_rgb[ix] : mp;
            x_enc = (sel && !m_ctrl[1]) ? m_enc[ix] : mp;
        end
        x_tag = tag;
        x_valid = 1;
        m_pos = ac ? m_pos + 1 : 0;
        if (we) begin
            if (a < 8)        m_enc[a] = d;
            else if (a < 16)  m_rgb[a - 8] = d;
            else if (a == 16) m_ctrl = d[2:0];
            else if (a == 17) m_blank = d;
        end
    endtask

    task automatic wr(input string tag, input logic [4:0] a, input logic [23:0] d);
        cyc(tag, 1'b1, a, d, 1'b0, 1'b0, 3'd0, 24'h0);
    endtask

    task automatic rnd_pix(input string tag, input logic ac);
        lf = nxt_rand(lf);
        cyc(tag, 1'b0, 5'd0, 24'h0, ac, lf[3], lf[6:4], lf[31:8]);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_enc[i] = '0; m_rgb[i] = '0; end
        m_ctrl = '0; m_blank = '0; m_pos = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state of the outputs
        tests++;
        if (enc_pix !== 24'h0 || rgb_pix !== 24'h0) begin
            fails++;
            $display("FAIL R1 enc=%h rgb=%h expected 0", enc_pix, rgb_pix);
        end
        rst = 1'b0;

        // R1: defaults: key high selects cleared tables, low passes main
        cyc("R1", 0, 0, 0, 1, 1, 3'd5, 24'hABCDEF);
        cyc("R1", 0, 0, 0, 1, 0, 3'd5, 24'h123456);
        cyc("R1", 0, 0, 0, 0, 0, 3'd0, 24'h777777);

        // R3: load both tables and the blanking colour
        for (int i = 0; i < 8; i++) wr("R3", 5'(i), 24'h100000 * (i + 1) + 24'h11);
        for (int i = 0; i < 8; i++) wr("R3", 5'(8 + i), 24'h000100 * (i + 1) + 24'hA00000);
        wr("R3", 5'd17, 24'h108080);

        // R11: unmapped writes change nothing
        wr("R11", 5'd18, 24'hFFFFFF);
        wr("R11", 5'd20, 24'h000007);
        wr("R11", 5'd31, 24'h00BEEF);
        for (int i = 0; i < 8; i++) cyc("R11", 0, 0, 0, 1, 0, 3'(i), 24'h0F0F00 + 24'(i));
        cyc("R11", 0, 0, 0, 0, 0, 0, 0);

        // R2 R4 R5: active-high keying, random pattern
        for (int i = 0; i < 30; i++) rnd_pix("R5", 1'b1);
        cyc("R2", 0, 0, 0, 1, 1, 3'd7, 24'h555555);
        cyc("R2", 0, 0, 0, 1, 0, 3'd7, 24'h666666);

        // R4: inverted key polarity
        wr("R4", 5'd16, 24'h000001);
        for (int i = 0; i < 30; i++) rnd_pix("R4", 1'b1);

        // R6: encoded keying off, RGB still keyed (both polarities)
        wr("R6", 5'd16, 24'h000002);
        for (int i = 0; i < 30; i++) rnd_pix("R6", 1'b1);
        wr("R6", 5'd16, 24'h000003);
        for (int i = 0; i < 20; i++) rnd_pix("R6", 1'b1);

        // R7: blanking interval with random inputs
        for (int i = 0; i < 10; i++) rnd_pix("R7", 1'b0);
        wr("R7", 5'd17, 24'h204060);
        for (int i = 0; i < 5; i++) rnd_pix("R7", 1'b0);

        // R8 R9: colour bars, a long line then a fresh line
        wr("R8", 5'd16, 24'h000004);
        for (int i = 0; i < 40; i++) rnd_pix("R9", 1'b1);
        for (int i = 0; i < 3; i++) rnd_pix("R8", 1'b0);
        for (int i = 0; i < 12; i++) rnd_pix("R8", 1'b1);

        // R10: write the entry in use during a bar segment
        cyc("R10", 1, 5'd3, 24'hC0FFEE, 1, 0, 0, 0);
        cyc("R10", 1, 5'd11, 24'hBADA55, 1, 0, 0, 0);
        for (int i = 0; i < 6; i++) rnd_pix("R10", 1'b1);
        // R10: keyed mode write to the selected entry
        wr("R10", 5'd16, 24'h000000);
        cyc("R10", 0, 0, 0, 1, 1, 3'd2, 24'h010101);
        cyc("R10", 1, 5'd2, 24'h0DD0DD, 1, 1, 3'd2, 24'h020202);
        cyc("R10", 0, 0, 0, 1, 1, 3'd2, 24'h030303);
        cyc("R10", 0, 0, 0, 0, 0, 0, 0);

        @(negedge clk);
        check_now();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule